// File: doc/BRIEF.md
# Two-Port RAM with Collision Semantics

This block is a clocked memory with one write port and one independent read port. Both ports carry their own address and can be used in the same clock cycle. Each port has a data output. The read output returns the word stored at the read address. The write-side output returns the word at the write address, either as it is after the current write or as it was before it.

A per-bit mask decides which bits of the addressed word an enabled write updates. Bits with a clear mask bit keep their stored value. A build-time parameter chooses between a registered read path with one cycle of latency and a combinational read path. In the combinational mode the write-side output always shows the currently stored word, so the new-versus-old choice has no effect there.

The reset clears only the output registers, never the array. Every word starts out holding a parameter value.

Top module: `twoport_ram`

## Requirements
- R1: After an enabled write with an all-ones mask to address A, a later read of A returns the written word, provided no write to A has happened in between.
- R2: An enabled write sets word bit i to data bit i where mask bit i is 1. Where mask bit i is 0, word bit i keeps its previous value.
- R3: In registered read mode (RD_MODE = RD_REGISTERED), `rd_data` shows the word at the `rd_addr` that was sampled at the previous rising edge of `clk`.
- R4: When a read and an enabled write hit the same address in the same cycle, `rd_data` returns the word held before that write.
- R5: In registered mode with WR_VIEW = WRV_NEW, `wr_q` shows the merged word one cycle after an enabled write. With the write disabled, it shows the stored word at `wr_addr`.
- R6: In registered mode with WR_VIEW = WRV_OLD, `wr_q` shows the word stored at `wr_addr` before the write of that cycle.
- R7: In combinational read mode (RD_MODE = RD_COMBINATIONAL), `rd_data` and `wr_q` show the current contents at `rd_addr` and `wr_addr` within the same cycle, before any write of that cycle takes effect.
- R8: While `wr_en` is 0, no word in the array changes, whatever `wr_data`, `wr_mask` and `wr_addr` hold.
- R9: While `rst_n` is 0, the registered outputs `rd_data` and `wr_q` are 0. Array contents survive a reset.
- R10: Before any write, every word holds the parameter INIT_WORD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write-port address (unsigned, 2 to 31 bits) |
| wr_data | input | DATA_W | Word to write |
| wr_mask | input | DATA_W | Per-bit write mask, 1 = update this bit |
| rd_addr | input | ADDR_W | Read-port address |
| rd_data | output | DATA_W | Read-port data |
| wr_q | output | DATA_W | Write-port data, new or old word at `wr_addr` |

## Verification
A write and a read can target the same word in the same cycle. This is the collision that the block must resolve: old data on the read port, and new or old data on the write port depending on the configuration. The bench provokes it by directed same-address cycles and by a long sweep over only four addresses, with partial masks mixed in. A reference array predicts each port for each cycle, and the outputs are compared one edge later. Three builds run side by side on the same inputs: new-data registered, old-data registered, and combinational. This lets one collision cycle be judged against every resolution rule at once.

// File: rtl/twoport_ram_pkg.sv
package twoport_ram_pkg;

    // What the write-side output reports in registered mode
    typedef enum logic {
        WRV_NEW = 1'b0,
        WRV_OLD = 1'b1
    } wr_view_e;

    // Read path timing
    typedef enum logic {
        RD_REGISTERED    = 1'b0,
        RD_COMBINATIONAL = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/twoport_ram_merge.sv
// Bitwise merge of write data into the stored word under a mask
module twoport_ram_merge #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] merged
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign merged[b] = mask[b] ? data[b] : stored[b];
    end

endmodule

// File: rtl/twoport_ram_store.sv
// Storage array: one write port, two combinational look-ups
module twoport_ram_store #(
    parameter int              ADDR_W    = 4,
    parameter int              DATA_W    = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wword,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword,
    output logic [DATA_W-1:0] wside_word
);

    localparam int DEPTH = 1 << ADDR_W;

    // Contents are not touched by reset; start value set here
    logic [DATA_W-1:0] mem_q [DEPTH] = '{default: INIT_WORD};

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wword;
        end
    end

    assign rword      = mem_q[raddr];
    assign wside_word = mem_q[waddr];

endmodule

// File: rtl/twoport_ram_outstage.sv
// Output stage: registered or pass-through, chosen at build time
module twoport_ram_outstage
    import twoport_ram_pkg::*;
#(
    parameter int       DATA_W  = 8,
    parameter wr_view_e WR_VIEW = WRV_NEW,
    parameter rd_mode_e RD_MODE = RD_REGISTERED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] rword,
    input  logic [DATA_W-1:0] wside_old,
    input  logic [DATA_W-1:0] wside_new,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_q
);

    if (RD_MODE == RD_REGISTERED) begin : g_reg

        typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic [DATA_W-1:0] wq;
        } out_t;

        out_t out_d, out_q;

        always_comb begin
            out_d    = out_q;
            out_d.rd = rword;
            if (WR_VIEW == WRV_NEW && we) begin
                out_d.wq = wside_new;
            end else begin
                out_d.wq = wside_old;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                out_q <= '0;
            end else begin
                out_q <= out_d;
            end
        end

        assign rd_data = out_q.rd;
        assign wr_q    = out_q.wq;

    end else begin : g_comb

        // Same-cycle view of the array; the write lands at the edge
        assign rd_data = rword;
        assign wr_q    = wside_old;

    end

endmodule

// File: rtl/twoport_ram.sv
module twoport_ram
    import twoport_ram_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 8,
    parameter logic [DATA_W-1:0] INIT_WORD = '0,
    parameter wr_view_e          WR_VIEW   = WRV_NEW,
    parameter rd_mode_e          RD_MODE   = RD_REGISTERED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wr_q
);

    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] wside_old;
    logic [DATA_W-1:0] wside_new;

    twoport_ram_store #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .INIT_WORD(INIT_WORD)
    ) u_store (
        .clk       (clk),
        .we        (wr_en),
        .waddr     (wr_addr),
        .wword     (wside_new),
        .raddr     (rd_addr),
        .rword     (rword),
        .wside_word(wside_old)
    );

    twoport_ram_merge #(
        .DATA_W(DATA_W)
    ) u_merge (
        .stored(wside_old),
        .data  (wr_data),
        .mask  (wr_mask),
        .merged(wside_new)
    );

    twoport_ram_outstage #(
        .DATA_W (DATA_W),
        .WR_VIEW(WR_VIEW),
        .RD_MODE(RD_MODE)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_en),
        .rword    (rword),
        .wside_old(wside_old),
        .wside_new(wside_new),
        .rd_data  (rd_data),
        .wr_q     (wr_q)
    );

endmodule

// File: rtl/twoport_ram_chk.sv
module twoport_ram_chk
    import twoport_ram_pkg::*;
#(
    parameter int       ADDR_W  = 4,
    parameter int       DATA_W  = 8,
    parameter wr_view_e WR_VIEW = WRV_NEW,
    parameter rd_mode_e RD_MODE = RD_REGISTERED
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] wr_mask,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] wr_q
);

    // Cycles since reset release, saturating, guards every $past
    logic [1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q != 2'd3) begin
            since_q <= since_q + 2'd1;
        end
    end

    if (RD_MODE == RD_REGISTERED) begin : g_reg

        // R9: registered outputs held at zero under reset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                assert_reset_zero_R9: assert (rd_data == '0 && wr_q == '0);
            end
        end

        // R1: full write, idle cycle, then read the same address
        assert_read_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (since_q == 2'd3) && $past(wr_en, 2) && (&$past(wr_mask, 2)) && !$past(wr_en)
            && ($past(rd_addr) == $past(wr_addr, 2))
            |-> rd_data == $past(wr_data, 2));

        if (WR_VIEW == WRV_NEW) begin : g_new
            // R2: masked bits of the write-side output follow the data
            assert_mask_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> ((wr_q ^ $past(wr_data)) & $past(wr_mask)) == '0);
            // R5: full-mask write is visible on wr_q one cycle later
            assert_new_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && (&wr_mask) |=> wr_q == $past(wr_data));
        end else begin : g_old
            // R6: write-side output shows the prior contents
            assert_old_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (since_q >= 2'd2) && $past(wr_en) && (&$past(wr_mask))
                && (wr_addr == $past(wr_addr))
                |=> wr_q == $past(wr_data, 2));
        end

    end else begin : g_comb

        // R7: previous write is visible combinationally on both ports
        assert_comb_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (since_q >= 2'd1) && $past(wr_en) && (&$past(wr_mask))
            && (rd_addr == $past(wr_addr))
            |-> rd_data == $past(wr_data));
        assert_comb_wside_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (since_q >= 2'd1) && $past(wr_en) && (&$past(wr_mask))
            && (wr_addr == $past(wr_addr))
            |-> wr_q == $past(wr_data));

    end

endmodule

bind twoport_ram twoport_ram_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WR_VIEW(WR_VIEW),
    .RD_MODE(RD_MODE)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wr_mask(wr_mask),
    .rd_addr(rd_addr),
    .rd_data(rd_data),
    .wr_q   (wr_q)
);

// File: tb/twoport_ram_tb.sv
module twoport_ram_tb;
    import twoport_ram_pkg::*;

    localparam int          AW    = 4;
    localparam int          DW    = 8;
    localparam logic [DW-1:0] INIT = 8'h3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] wr_mask = '0;
    logic [AW-1:0] rd_addr = '0;

    logic [DW-1:0] rd_new, wq_new, rd_old, wq_old, rd_cmb, wq_cmb;

    always #10 clk = ~clk;  // 50 MHz

    twoport_ram #(.ADDR_W(AW), .DATA_W(DW), .INIT_WORD(INIT),
                  .WR_VIEW(WRV_NEW), .RD_MODE(RD_REGISTERED)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_new), .wr_q(wq_new));

    twoport_ram #(.ADDR_W(AW), .DATA_W(DW), .INIT_WORD(INIT),
                  .WR_VIEW(WRV_OLD), .RD_MODE(RD_REGISTERED)) u_dut_old (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_old), .wr_q(wq_old));

    twoport_ram #(.ADDR_W(AW), .DATA_W(DW), .INIT_WORD(INIT),
                  .WR_VIEW(WRV_NEW), .RD_MODE(RD_COMBINATIONAL)) u_dut_cmb (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_cmb), .wr_q(wq_cmb));

    typedef struct {
        logic [DW-1:0] rd;
        logic [DW-1:0] wnew;
        logic [DW-1:0] wold;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] model [1 << AW];
    int            checks = 0;
    int            errors = 0;

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle, push registered expectations, check combinational build
    task automatic drive(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                         input logic [DW-1:0] wm, input logic [AW-1:0] ra, input string tag);
        exp_t          it;
        logic [DW-1:0] prior;
        logic [DW-1:0] merged;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; wr_mask = wm; rd_addr = ra;
        prior   = model[wa];
        merged  = (prior & ~wm) | (wd & wm);
        it.rd   = model[ra];
        it.wnew = we ? merged : prior;
        it.wold = prior;
        it.tag  = tag;
        sb.push_back(it);
        #1;
        check({"R7 rd ", tag}, rd_cmb, model[ra]);
        check({"R7 wq ", tag}, wq_cmb, prior);
        if (we) model[wa] = merged;
    endtask

    // Monitor: compare registered builds shortly after each edge
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                check({"R3 rd new ", it.tag}, rd_new, it.rd);
                check({"R3 rd old ", it.tag}, rd_old, it.rd);
                check({"R5 wq ", it.tag}, wq_new, it.wnew);
                check({"R6 wq ", it.tag}, wq_old, it.wold);
            end
        end
    end

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(posedge clk);
        #2;
        check("R9 rd zero", rd_new, '0);
        check("R9 wq zero", wq_new, '0);
        check("R9 old rd zero", rd_old, '0);
        check("R9 old wq zero", wq_old, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) model[i] = INIT;
        repeat (3) @(posedge clk);
        #2;
        check("R9 initial rd", rd_new, '0);
        check("R9 initial wq", wq_new, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: untouched words hold INIT
        drive(1'b0, 4'd9, 8'h00, 8'h00, 4'd5, "R10");
        // R4: collision, full write while reading the same word
        drive(1'b1, 4'd3, 8'h5A, 8'hFF, 4'd3, "R4 collide");
        // R1: read back
        drive(1'b0, 4'd0, 8'h00, 8'h00, 4'd3, "R1 readback");
        // R2: masked write touching bits 5..2 only
        drive(1'b1, 4'd3, 8'h0F, 8'h3C, 4'd3, "R2 masked");
        drive(1'b0, 4'd3, 8'h00, 8'h00, 4'd3, "R2 readback");
        // R8: disabled write with all-ones mask changes nothing
        drive(1'b0, 4'd3, 8'hFF, 8'hFF, 4'd3, "R8 idle");
        drive(1'b0, 4'd3, 8'h00, 8'h00, 4'd3, "R8 readback");
        // R3: back-to-back writes with pipelined reads
        drive(1'b1, 4'd7, 8'h11, 8'hFF, 4'd3, "R3 a");
        drive(1'b1, 4'd8, 8'h22, 8'hFF, 4'd7, "R3 b");
        drive(1'b0, 4'd0, 8'h00, 8'h00, 4'd8, "R3 c");
        // Sweep over four addresses to force frequent collisions
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] wa;
            logic [AW-1:0] ra;
            wa = AW'($urandom_range(0, 3));
            ra = (n % 3 == 0) ? wa : AW'($urandom_range(0, 3));
            drive(1'($urandom_range(0, 1)), wa, 8'($urandom),
                  (n % 2 == 0) ? 8'hFF : 8'($urandom), ra, "R4 sweep");
        end
        @(posedge clk);
        #3;
        // R9: contents survive a reset
        pulse_reset();
        drive(1'b0, 4'd0, 8'h00, 8'h00, 4'd7, "R9 keep");
        drive(1'b0, 4'd8, 8'h00, 8'h00, 4'd8, "R9 keep");
        @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule